// File: doc/BRIEF.md
# Programmable Wait-State Handshake Generator

This block turns the progress of a DRAM access into the ready handshake a CPU bus expects. One configuration bit picks the convention of the single handshake pin. In wait mode the pin is pulled low while the processor has to stall. In acknowledge mode the pin idles high and drops low once the access has completed. A 2-bit delay code places the completion point. It can fall at the moment the access row strobe asserts, half a clock later, one clock later, or one and a half clocks later. The mapping from code to delay differs between the two conventions. Some codes also skip the wait entirely for accesses that were not held off.

A second 2-bit code governs the column cycles of a burst. These begin once the access has completed and the column enables have been seen asserted. When the column enables drop while the request is still held, the handshake can ignore the gap, track the enables directly, or hold the wait until the next rising or falling clock edge after the enables return. A wait-increase input stretches a pending delay by one whole clock for each rising edge at which it is sampled high. Half-clock points are produced by registers clocked on the falling edge. The row and column strobes themselves are generated elsewhere.

Top module: `wait_ack_gen`

## Requirements
- R1: While `acc_req` is low the handshake pin `hs_out` is high in both conventions.
- R2: With `ack_mode`=0 (wait convention) `hs_out` is low exactly while a requested access is not yet complete. With `ack_mode`=1 (acknowledge convention) `hs_out` is low exactly while a requested access is complete.
- R3: With `dly_code`=00, completion coincides with `acc_ras` being high. In the wait convention an access with `delayed_acc`=0 never waits.
- R4: With `dly_code`=01, the wait convention completes in the low clock phase after `acc_ras` rises. The acknowledge convention completes at the first rising edge after it.
- R5: With `dly_code`=10, the wait convention never waits when `delayed_acc`=0 and otherwise completes in the low phase after `acc_ras`. The acknowledge convention completes in that low phase.
- R6: With `dly_code`=11, the wait convention completes at the first rising edge after `acc_ras`. The acknowledge convention completes in the low phase that follows that edge.
- R7: Each rising edge that samples `wait_inc` high while completion is still pending postpones completion by one clock. A sample taken after completion has no effect.
- R8: With `burst_code`=00, a drop of all bits of `cas_en` after completion leaves the handshake in its ready state.
- R9: With `burst_code`=11, after completion the handshake shows a wait in the same phase in which all bits of `cas_en` are low, and is ready again as soon as any bit rises.
- R10: With `burst_code`=01, a wait starts when all bits of `cas_en` drop and ends at the first rising edge that samples any bit high again.
- R11: With `burst_code`=10, a wait starts when all bits of `cas_en` drop and ends in the first low clock phase after any bit is high again.
- R12: A wait-convention access with `delayed_acc`=1 and `dly_code`=00 holds `hs_out` low from the request until `acc_ras` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising and falling edges both used |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_mode | input | 1 | 0 = wait convention, 1 = acknowledge convention |
| dly_code | input | 2 | Completion delay code after access row strobe |
| burst_code | input | 2 | Burst column-gap behaviour code |
| acc_req | input | 1 | Access request held for the whole access |
| acc_ras | input | 1 | High while the access row strobe is asserted |
| delayed_acc | input | 1 | Access was held off before its row strobe |
| cas_en | input | NCAS | Column enables, high = asserted |
| wait_inc | input | 1 | Dynamic wait-increase request |
| hs_out | output | 1 | Handshake pin level |

## Verification
A wait-increase sample and the completion of the delay can fall on the same rising edge. The bench holds `wait_inc` high across the first rising edge after the row strobe. Under code 11 in the wait convention and codes 01 and 11 in the acknowledge convention, completion is still pending at that edge, so the pin must stay in its wait level for two more half-phases. Under code 01 in the wait convention the access has already completed at that edge, and the pin must not move. A second overlap is a column enable returning in the same clock in which the burst hold register samples it. The bench checks the half-phase on either side of the release edge for each burst code.

// File: rtl/wait_ack_pkg.sv
package wait_ack_pkg;

  // Half-clock phases between access row strobe and completion.
  function automatic logic [2:0] base_halves(input logic dtack, input logic [1:0] code);
    logic [2:0] h;
    if (dtack) begin
      case (code)
        2'b00:   h = 3'd0;
        2'b01:   h = 3'd2;
        2'b10:   h = 3'd1;
        default: h = 3'd3;
      endcase
    end else begin
      case (code)
        2'b00:   h = 3'd0;
        2'b01:   h = 3'd1;
        2'b10:   h = 3'd1;
        default: h = 3'd2;
      endcase
    end
    return h;
  endfunction

  // Wait convention codes 00/10 skip waiting on non-delayed accesses.
  function automatic logic skip_wait(input logic dtack, input logic [1:0] code,
                                     input logic delayed);
    return !dtack && !delayed && (code == 2'b00 || code == 2'b10);
  endfunction

  // Required half-phases: base plus two per extension clock.
  function automatic logic [7:0] need_halves(input logic [2:0] base, input logic [6:0] ext);
    return {5'd0, base} + {ext, 1'b0};
  endfunction

  // Pin level from convention and completion.
  function automatic logic pin_level(input logic dtack, input logic req, input logic done);
    return dtack ? !done : !(req && !done);
  endfunction

endpackage

// File: rtl/wait_delay_track.sv
module wait_delay_track
  import wait_ack_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_req,
  input  logic             acc_ras,
  input  logic             wait_inc,
  input  logic [2:0]       base,
  input  logic             skip,
  output logic             dly_done,
  output logic [CNT_W-1:0] ext_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] pos_cnt;
  logic [CNT_W-1:0] neg_cnt;
  logic [CNT_W:0]   elapsed;
  logic [7:0]       need;
  logic             pend;

  // Rising-edge phase counter while the row strobe is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pos_cnt <= '0;
    else if (!acc_req)                      pos_cnt <= '0;
    else if (acc_ras && pos_cnt != CNT_MAX) pos_cnt <= pos_cnt + 1'b1;
  end

  // Falling-edge phase counter gives the half-clock points.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                             neg_cnt <= '0;
    else if (!acc_req)                      neg_cnt <= '0;
    else if (acc_ras && neg_cnt != CNT_MAX) neg_cnt <= neg_cnt + 1'b1;
  end

  assign pend = acc_req && !dly_done;

  // Dynamic extension, one clock per sampled request while pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       ext_cnt <= '0;
    else if (!acc_req)                                ext_cnt <= '0;
    else if (pend && wait_inc && ext_cnt != CNT_MAX)  ext_cnt <= ext_cnt + 1'b1;
  end

  assign elapsed  = {1'b0, pos_cnt} + {1'b0, neg_cnt};
  assign need     = need_halves(base, 7'(ext_cnt));
  assign dly_done = skip || (acc_ras && (8'(elapsed) >= need));

endmodule

// File: rtl/burst_gap_track.sv
module burst_gap_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_req,
  input  logic       cas_any,
  input  logic [1:0] burst_code,
  input  logic       dly_done,
  output logic       primed,
  output logic       burst_wait
);
  logic hold_p;
  logic hold_n;
  logic gap_raw;

  // Burst phase opens after completion with column enables seen asserted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   primed <= 1'b0;
    else if (!acc_req)            primed <= 1'b0;
    else if (dly_done && cas_any) primed <= 1'b1;
  end

  // Gap seen at the last rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_p <= 1'b0;
    else if (!acc_req) hold_p <= 1'b0;
    else               hold_p <= !cas_any;
  end

  // Gap seen at the last falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)        hold_n <= 1'b0;
    else if (!acc_req) hold_n <= 1'b0;
    else               hold_n <= !cas_any;
  end

  always_comb begin
    case (burst_code)
      2'b00:   gap_raw = 1'b0;
      2'b01:   gap_raw = !cas_any || hold_p;
      2'b10:   gap_raw = !cas_any || hold_n;
      default: gap_raw = !cas_any;
    endcase
  end

  assign burst_wait = primed && gap_raw;

endmodule

// File: rtl/wait_ack_gen.sv
module wait_ack_gen
  import wait_ack_pkg::*;
#(
  parameter int NCAS  = 4,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_mode,
  input  logic [1:0]      dly_code,
  input  logic [1:0]      burst_code,
  input  logic            acc_req,
  input  logic            acc_ras,
  input  logic            delayed_acc,
  input  logic [NCAS-1:0] cas_en,
  input  logic            wait_inc,
  output logic            hs_out
);
  logic             cas_any;
  logic [2:0]       base;
  logic             skip;
  logic             dly_done;
  logic [CNT_W-1:0] ext_cnt;
  logic             primed;
  logic             burst_wait;
  logic             acc_done;
  logic [NCAS-1:0]  cas_or;

  // Ripple OR of the column enables.
  generate
    for (genvar g = 0; g < NCAS; g++) begin : g_cas
      if (g == 0) begin : g_first
        assign cas_or[g] = cas_en[g];
      end else begin : g_rest
        assign cas_or[g] = cas_or[g-1] | cas_en[g];
      end
    end
  endgenerate

  assign cas_any = cas_or[NCAS-1];
  assign base    = base_halves(ack_mode, dly_code);
  assign skip    = skip_wait(ack_mode, dly_code, delayed_acc);

  wait_delay_track #(.CNT_W(CNT_W)) dly_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .acc_ras  (acc_ras),
    .wait_inc (wait_inc),
    .base     (base),
    .skip     (skip),
    .dly_done (dly_done),
    .ext_cnt  (ext_cnt)
  );

  burst_gap_track gap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_req    (acc_req),
    .cas_any    (cas_any),
    .burst_code (burst_code),
    .dly_done   (dly_done),
    .primed     (primed),
    .burst_wait (burst_wait)
  );

  assign acc_done = acc_req && dly_done && !burst_wait;
  assign hs_out   = pin_level(ack_mode, acc_req, acc_done);

endmodule

// File: rtl/wait_ack_chk.sv
module wait_ack_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_mode,
  input logic [1:0]       dly_code,
  input logic [1:0]       burst_code,
  input logic             acc_req,
  input logic             acc_ras,
  input logic             delayed_acc,
  input logic             cas_any,
  input logic             hs_out,
  input logic             dly_done,
  input logic [CNT_W-1:0] ext_cnt,
  input logic             primed
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> hs_out);

  // R3 / R8: acknowledge at once with code 00 and no burst waits
  a_r3_ack_now: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mode && dly_code == 2'b00 && burst_code == 2'b00 && acc_req && acc_ras) |-> !hs_out);

  // R5: wait convention, non-delayed, code 10 never stalls
  a_r5_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_mode && dly_code == 2'b10 && !delayed_acc && burst_code == 2'b00) |-> hs_out);

  a_r7_ext_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && $past(acc_req)) |-> ext_cnt >= $past(ext_cnt));

  // R2: completion is held while the strobe and configuration stay put
  a_r2_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dly_done && acc_req && acc_ras) && acc_req && acc_ras &&
     $stable(dly_code) && $stable(ack_mode) && $stable(delayed_acc)) |-> dly_done);

  a_r9_follow_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_code == 2'b11 && primed && !cas_any && acc_req) |-> hs_out == ack_mode);

endmodule

bind wait_ack_gen wait_ack_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_mode    (ack_mode),
  .dly_code    (dly_code),
  .burst_code  (burst_code),
  .acc_req     (acc_req),
  .acc_ras     (acc_ras),
  .delayed_acc (delayed_acc),
  .cas_any     (cas_any),
  .hs_out      (hs_out),
  .dly_done    (dly_done),
  .ext_cnt     (ext_cnt),
  .primed      (primed)
);

// File: tb/wait_ack_gen_tb_top.sv
module wait_ack_gen_tb_top;
  localparam int NCAS = 4;
  localparam int NVEC = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ack_mode = 1'b0;
  logic [1:0]      dly_code = 2'b00;
  logic [1:0]      burst_code = 2'b00;
  logic            acc_req = 1'b0;
  logic            acc_ras = 1'b0;
  logic            delayed_acc = 1'b0;
  logic [NCAS-1:0] cas_en = '0;
  logic            wait_inc = 1'b0;
  logic            hs_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wait_ack_gen #(.NCAS(NCAS), .CNT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ack_mode(ack_mode), .dly_code(dly_code),
    .burst_code(burst_code), .acc_req(acc_req), .acc_ras(acc_ras),
    .delayed_acc(delayed_acc), .cas_en(cas_en), .wait_inc(wait_inc), .hs_out(hs_out)
  );

  // {mode, code, delayed, inc, pin at s0..s4}: s0 high phase of RAS edge,
  // s1 next low phase, s2 next high phase, s3, s4.
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 1'b0, 1'b0, 5'b11111},
    {1'b0, 2'b00, 1'b1, 1'b0, 5'b11111},
    {1'b0, 2'b01, 1'b0, 1'b0, 5'b01111},
    {1'b0, 2'b10, 1'b0, 1'b0, 5'b11111},
    {1'b0, 2'b10, 1'b1, 1'b0, 5'b01111},
    {1'b0, 2'b11, 1'b0, 1'b0, 5'b00111},
    {1'b1, 2'b00, 1'b0, 1'b0, 5'b00000},
    {1'b1, 2'b01, 1'b0, 1'b0, 5'b11000},
    {1'b1, 2'b10, 1'b0, 1'b0, 5'b10000},
    {1'b1, 2'b11, 1'b0, 1'b0, 5'b11100},
    {1'b0, 2'b11, 1'b0, 1'b1, 5'b00001},
    {1'b1, 2'b11, 1'b0, 1'b1, 5'b11111},
    {1'b1, 2'b01, 1'b0, 1'b1, 5'b11110},
    {1'b0, 2'b01, 1'b0, 1'b1, 5'b01111}
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (hs_out !== exp) begin
      failures++;
      $display("FAIL %s at %0t: hs_out=%b expected=%b", req, $time, hs_out, exp);
    end
  endtask

  function automatic string vec_req(input logic [1:0] code, input logic inc);
    if (inc) return "R7";
    case (code)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic end_access();
    @(posedge clk); #1;
    acc_req = 1'b0; acc_ras = 1'b0; cas_en = '0; wait_inc = 1'b0; delayed_acc = 1'b0;
    #1 check("R1", 1'b1);
    repeat (2) @(posedge clk);
  endtask

  // Burst gap: cas drops one clock after RAS, returns a clock later.
  task automatic run_burst(input logic mode, input logic [1:0] bc, input logic [3:0] exp,
                           input string req);
    @(posedge clk); #1;
    ack_mode = mode; dly_code = 2'b00; burst_code = bc; delayed_acc = 1'b1;
    acc_req = 1'b1; acc_ras = 1'b1; cas_en = '1;
    @(posedge clk); #1 cas_en = '0;
    #1 check(req, exp[3]);
    @(posedge clk); #1 cas_en = 4'b0010;
    #1 check(req, exp[2]);
    @(negedge clk); #2 check(req, exp[1]);
    @(posedge clk); #2 check(req, exp[0]);
    end_access();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Reset state in both conventions (R1)
    #12 check("R1", 1'b1);
    ack_mode = 1'b1;
    #1 check("R1", 1'b1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Table walk: delay codes and extension (R2..R7)
    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1;
      ack_mode = VEC[i][9]; dly_code = VEC[i][8:7]; delayed_acc = VEC[i][6];
      wait_inc = VEC[i][5]; burst_code = 2'b00;
      acc_req = 1'b1; acc_ras = 1'b1; cas_en = '1;
      #1 check(vec_req(VEC[i][8:7], VEC[i][5]), VEC[i][4]);
      @(negedge clk); #2 check(vec_req(VEC[i][8:7], VEC[i][5]), VEC[i][3]);
      @(posedge clk); #1 wait_inc = 1'b0;
      #1 check(vec_req(VEC[i][8:7], VEC[i][5]), VEC[i][2]);
      @(negedge clk); #2 check(vec_req(VEC[i][8:7], VEC[i][5]), VEC[i][1]);
      @(posedge clk); #2 check("R2", VEC[i][0]);
      end_access();
    end

    // R12: delayed wait-convention access held until row strobe
    @(posedge clk); #1;
    ack_mode = 1'b0; dly_code = 2'b00; burst_code = 2'b00; delayed_acc = 1'b1;
    acc_req = 1'b1; acc_ras = 1'b0; cas_en = '1;
    #1 check("R12", 1'b0);
    @(negedge clk); #2 check("R12", 1'b0);
    @(posedge clk); #1 acc_ras = 1'b1;
    #1 check("R12", 1'b1);
    end_access();

    // Burst gap behaviour (R8..R11), acknowledge convention: 0 = ready
    run_burst(1'b1, 2'b00, 4'b0000, "R8");
    run_burst(1'b1, 2'b11, 4'b1000, "R9");
    run_burst(1'b1, 2'b01, 4'b1110, "R10");
    run_burst(1'b1, 2'b10, 4'b1100, "R11");
    // Wait convention: 0 = stall
    run_burst(1'b0, 2'b01, 4'b0001, "R10");
    run_burst(1'b0, 2'b00, 4'b1111, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule